// File: doc/BRIEF.md
# Sync Hunt and Loop-Transmit Controller

This block sits in one channel of a synchronous serial controller. On every receive bit enable it shifts the incoming serial bit into a history window and compares the most recent bits with a programmed sync pattern. The pattern length depends on the framing mode and on a short-sync flag. Monosync uses 8 bits, or 6 when the flag is set. Bisync uses 16 bits, or 12 when the flag is set. Bit-oriented (SDLC) framing always uses 8 bits. An external-sync mode takes the sync event from a separate input instead of the pattern.

In loop mode the transmit line is held idle at the mark level (1) until sync has been found. After sync, a character counter marks each character boundary. The transmitter is released on the first boundary, and any programmed break is cleared in that same cycle. Clearing loop mode, or leaving the synchronous modes, sends the block back to hunting. The loop flag and the short-sync flag are held in a small configuration register. A channel reset clears both flags.

Top module: `slt_loop_ctrl`

## Requirements
- R1: After hardware reset or channel reset, sync_found_o, char_bnd_o, tx_en_o and brk_o read 0, and the loop and short-sync flags are cleared.
- R2: While hunting, each rx_bit_en_i shifts rx_bit_i in. A match is declared when the last N received bits equal bits N-1..0 of sync_pat_i, with the first-received bit compared with bit N-1. At least N bits must have been received since the hunt began. sync_found_o rises at the clock edge that samples the enable carrying the final bit.
- R3: The receive match length N is 8 in monosync (6 with short-sync set), 16 in bisync (12 with short-sync set), and 8 in SDLC, where short-sync is ignored. Mode codes on mode_i: 0 async, 1 monosync, 2 bisync, 3 SDLC, 4 external sync. Codes 5 to 7 behave as async.
- R4: In external-sync mode, sync is found on any bit enable while ext_sync_i is 1, whatever sync_pat_i holds.
- R5: After sync, char_bnd_o is a one-cycle pulse after every L-th bit enable, where L is 6 in monosync or external-sync mode with short-sync set, and 8 otherwise.
- R6: tx_en_o asserts in the same cycle as the first char_bnd_o after sync and stays high until the block returns to hunting.
- R7: With brk_o set, tx_line_o is 0. Otherwise, in active loop mode before release, tx_line_o is 1. In all other cases tx_line_o follows tx_data_i.
- R8: brk_wr_i loads brk_val_i into brk_o. At the release edge the break is cleared, and this clear takes priority over a break write in the same cycle.
- R9: When the loop flag reads 0, or mode_i is not a synchronous mode, sync_found_o and tx_en_o are 0 from the next clock edge on, and the hunt restarts with an empty history.
- R10: In async mode the loop flag has no effect: no hunt takes place, and tx_line_o follows tx_data_i unless a break is set.
- R11: tx_sync_len_o reports the transmit sync length. It is 8 in monosync (6 with short-sync set), 16 in bisync whatever the short-sync flag, 8 in SDLC, 8 in external-sync mode (6 with short-sync set), and 0 in async.
- R12: cfg_wr_i loads cfg_loop_i and cfg_short_i into the flags. chan_rst_i clears the flags, the break and the hunt state, and takes priority over a configuration write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_rst_i | input | 1 | Synchronous channel reset |
| cfg_wr_i | input | 1 | Configuration flag write strobe |
| cfg_loop_i | input | 1 | Loop-mode flag value |
| cfg_short_i | input | 1 | Short-sync flag value |
| mode_i | input | 3 | Framing mode code |
| sync_pat_i | input | SYNC_W | Programmed sync pattern |
| rx_bit_i | input | 1 | Receive data bit |
| rx_bit_en_i | input | 1 | Receive bit enable |
| ext_sync_i | input | 1 | External sync event |
| brk_wr_i | input | 1 | Break write strobe |
| brk_val_i | input | 1 | Break value to write |
| tx_data_i | input | 1 | Transmit data from the serializer |
| sync_found_o | output | 1 | Sync has been found |
| char_bnd_o | output | 1 | Character boundary pulse |
| tx_en_o | output | 1 | Transmitter released |
| brk_o | output | 1 | Break active |
| tx_line_o | output | 1 | Gated transmit line |
| tx_sync_len_o | output | LEN_W | Transmit sync length in bits |

## Verification
The release edge and a break write can land in the same cycle. The bench provokes this by holding brk_wr_i with value 1 through the entire post-sync window, so the write collides with the automatic clear. It then expects brk_o to drop for exactly one cycle before the write takes hold again. A channel reset issued together with a configuration write is judged the same way: the reset must win. A bit-by-bit reference model, compared on every clock, decides the expected outcome in both cases.

// File: rtl/slt_pkg.sv
package slt_pkg;

  typedef enum logic [2:0] {
    MODE_ASYNC = 3'd0,
    MODE_MONO  = 3'd1,
    MODE_BI    = 3'd2,
    MODE_SDLC  = 3'd3,
    MODE_EXT   = 3'd4
  } slt_mode_e;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_SYNCED = 2'd1,
    ST_ACTIVE = 2'd2
  } slt_state_e;

  function automatic logic is_sync_mode(logic [2:0] m);
    logic r;
    case (m)
      MODE_MONO, MODE_BI, MODE_SDLC, MODE_EXT: r = 1'b1;
      default:                                 r = 1'b0;
    endcase
    return r;
  endfunction

  // receive match length in bits
  function automatic int rx_sync_len(logic [2:0] m, logic short_sync);
    int r;
    case (m)
      MODE_MONO: r = short_sync ? 6 : 8;
      MODE_BI:   r = short_sync ? 12 : 16;
      MODE_SDLC: r = 8;
      default:   r = 0;
    endcase
    return r;
  endfunction

  // transmit sync length in bits
  function automatic int tx_sync_len(logic [2:0] m, logic short_sync);
    int r;
    case (m)
      MODE_MONO, MODE_EXT: r = short_sync ? 6 : 8;
      MODE_BI:             r = 16;
      MODE_SDLC:           r = 8;
      default:             r = 0;
    endcase
    return r;
  endfunction

  // character length used for boundary strobes
  function automatic int char_len(logic [2:0] m, logic short_sync);
    int r;
    if ((m == MODE_MONO || m == MODE_EXT) && short_sync) r = 6;
    else                                                  r = 8;
    return r;
  endfunction

endpackage

// File: rtl/slt_rst_sync.sv
module slt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/slt_sync_match.sv
module slt_sync_match #(
  parameter  int SYNC_W = 16,
  localparam int LEN_W  = $clog2(SYNC_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_en_i,
  input  logic              bit_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SYNC_W-1:0] pat_i,
  output logic              hit_o
);

  logic [SYNC_W-1:0] hist_q, hist_d, hist_nxt, len_mask;
  logic [LEN_W-1:0]  fill_q, fill_d, fill_nxt;

  for (genvar g = 0; g < SYNC_W; g++) begin : g_mask
    assign len_mask[g] = (len_i > LEN_W'(g));
  end

  always_comb begin
    hist_nxt = {hist_q[SYNC_W-2:0], bit_i};
    fill_nxt = (fill_q == LEN_W'(SYNC_W)) ? fill_q : fill_q + 1'b1;
    hit_o    = shift_en_i && (len_i != '0) && (fill_nxt >= len_i) &&
               (((hist_nxt ^ pat_i) & len_mask) == '0);
    hist_d   = hist_q;
    fill_d   = fill_q;
    if (clr_i) begin
      hist_d = '0;
      fill_d = '0;
    end else if (shift_en_i) begin
      hist_d = hist_nxt;
      fill_d = fill_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

endmodule

// File: rtl/slt_char_count.sv
module slt_char_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    wrap_o  = en_i && !clr_i && (cnt_inc == len_i);
    cnt_d   = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (en_i)   cnt_d = wrap_o ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/slt_loop_gate.sv
module slt_loop_gate
  import slt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_rst_i,
  input  logic active_i,
  input  logic hit_i,
  input  logic wrap_i,
  input  logic brk_wr_i,
  input  logic brk_val_i,
  input  logic tx_data_i,
  output logic hunting_o,
  output logic found_o,
  output logic tx_en_o,
  output logic bnd_o,
  output logic brk_o,
  output logic tx_line_o
);

  slt_state_e state_q, state_d;
  logic       bnd_q, bnd_d;
  logic       brk_q, brk_d;
  logic       release_s;

  always_comb begin
    state_d   = state_q;
    release_s = 1'b0;
    bnd_d     = 1'b0;
    if (chan_rst_i || !active_i) begin
      state_d = ST_HUNT;
    end else begin
      case (state_q)
        ST_HUNT:   if (hit_i) state_d = ST_SYNCED;
        ST_SYNCED: if (wrap_i) begin
          state_d   = ST_ACTIVE;
          release_s = 1'b1;
        end
        ST_ACTIVE: state_d = ST_ACTIVE;
        default:   state_d = ST_HUNT;
      endcase
      bnd_d = wrap_i && (state_q != ST_HUNT);
    end

    brk_d = brk_q;
    if (chan_rst_i)     brk_d = 1'b0;
    else if (release_s) brk_d = 1'b0;
    else if (brk_wr_i)  brk_d = brk_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      bnd_q   <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bnd_q   <= bnd_d;
      brk_q   <= brk_d;
    end
  end

  assign hunting_o = active_i && (state_q == ST_HUNT);
  assign found_o   = (state_q != ST_HUNT);
  assign tx_en_o   = (state_q == ST_ACTIVE);
  assign bnd_o     = bnd_q;
  assign brk_o     = brk_q;

  always_comb begin
    if (brk_q)                                tx_line_o = 1'b0;
    else if (active_i && state_q != ST_ACTIVE) tx_line_o = 1'b1;
    else                                      tx_line_o = tx_data_i;
  end

endmodule

// File: rtl/slt_loop_ctrl.sv
module slt_loop_ctrl
  import slt_pkg::*;
#(
  parameter  int SYNC_W   = 16,
  parameter  int CHAR_MAX = 8,
  localparam int LEN_W    = $clog2(SYNC_W + 1),
  localparam int CNT_W    = $clog2(CHAR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_loop_i,
  input  logic              cfg_short_i,
  input  logic [2:0]        mode_i,
  input  logic [SYNC_W-1:0] sync_pat_i,
  input  logic              rx_bit_i,
  input  logic              rx_bit_en_i,
  input  logic              ext_sync_i,
  input  logic              brk_wr_i,
  input  logic              brk_val_i,
  input  logic              tx_data_i,
  output logic              sync_found_o,
  output logic              char_bnd_o,
  output logic              tx_en_o,
  output logic              brk_o,
  output logic              tx_line_o,
  output logic [LEN_W-1:0]  tx_sync_len_o
);

  logic             rst_n_s;
  logic             loop_q, loop_d, short_q, short_d;
  logic             loop_act;
  logic [LEN_W-1:0] rx_len;
  logic [CNT_W-1:0] chr_len;
  logic             hunting, shift_en, match_clr, pat_hit, hit;
  logic             cnt_en, cnt_clr, wrap;

  slt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  // configuration flags
  always_comb begin
    loop_d  = loop_q;
    short_d = short_q;
    if (chan_rst_i) begin
      loop_d  = 1'b0;
      short_d = 1'b0;
    end else if (cfg_wr_i) begin
      loop_d  = cfg_loop_i;
      short_d = cfg_short_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      loop_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      loop_q  <= loop_d;
      short_q <= short_d;
    end
  end

  assign loop_act      = loop_q && is_sync_mode(mode_i);
  assign rx_len        = LEN_W'(rx_sync_len(mode_i, short_q));
  assign chr_len       = CNT_W'(char_len(mode_i, short_q));
  assign tx_sync_len_o = LEN_W'(tx_sync_len(mode_i, short_q));

  assign shift_en  = hunting && rx_bit_en_i;
  assign match_clr = chan_rst_i || !loop_act;

  slt_sync_match #(.SYNC_W(SYNC_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clr_i      (match_clr),
    .shift_en_i (shift_en),
    .bit_i      (rx_bit_i),
    .len_i      (rx_len),
    .pat_i      (sync_pat_i),
    .hit_o      (pat_hit)
  );

  assign hit = (mode_i == MODE_EXT) ? (shift_en && ext_sync_i) : pat_hit;

  assign cnt_en  = rx_bit_en_i && loop_act && sync_found_o;
  assign cnt_clr = chan_rst_i || !loop_act || !sync_found_o;

  slt_char_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .len_i  (chr_len),
    .wrap_o (wrap)
  );

  slt_loop_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .chan_rst_i (chan_rst_i),
    .active_i   (loop_act),
    .hit_i      (hit),
    .wrap_i     (wrap),
    .brk_wr_i   (brk_wr_i),
    .brk_val_i  (brk_val_i),
    .tx_data_i  (tx_data_i),
    .hunting_o  (hunting),
    .found_o    (sync_found_o),
    .tx_en_o    (tx_en_o),
    .bnd_o      (char_bnd_o),
    .brk_o      (brk_o),
    .tx_line_o  (tx_line_o)
  );

endmodule

// File: rtl/slt_loop_ctrl_chk.sv
module slt_loop_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic chan_rst,
  input logic loop_act,
  input logic loop_q,
  input logic found,
  input logic tx_en,
  input logic bnd,
  input logic brk,
  input logic tx_line,
  input logic tx_data
);

  assert_release_on_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> bnd);

  assert_break_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> !brk);

  assert_mark_while_hunting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_act && !found && !brk) |-> tx_line);

  assert_break_spaces_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !tx_line);

  assert_hunt_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !loop_act) |=> (!found && !tx_en));

  assert_boundary_needs_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |-> found);

  assert_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_act && !brk) |-> (tx_line == tx_data));

  assert_chan_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (!found && !brk && !loop_q));

endmodule

bind slt_loop_ctrl slt_loop_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_rst (chan_rst_i),
  .loop_act (loop_act),
  .loop_q   (loop_q),
  .found    (sync_found_o),
  .tx_en    (tx_en_o),
  .bnd      (char_bnd_o),
  .brk      (brk_o),
  .tx_line  (tx_line_o),
  .tx_data  (tx_data_i)
);

// File: tb/slt_loop_ctrl_tb.sv
module slt_loop_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chan_rst_i, cfg_wr_i, cfg_loop_i, cfg_short_i;
  logic [2:0]  mode_i;
  logic [15:0] sync_pat_i;
  logic        rx_bit_i, rx_bit_en_i, ext_sync_i;
  logic        brk_wr_i, brk_val_i, tx_data_i;
  logic        sync_found_o, char_bnd_o, tx_en_o, brk_o, tx_line_o;
  logic [4:0]  tx_sync_len_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  bit    done  = 0;
  bit    gaps  = 0;
  string phase = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  slt_loop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .chan_rst_i(chan_rst_i), .cfg_wr_i(cfg_wr_i),
    .cfg_loop_i(cfg_loop_i), .cfg_short_i(cfg_short_i), .mode_i(mode_i),
    .sync_pat_i(sync_pat_i), .rx_bit_i(rx_bit_i), .rx_bit_en_i(rx_bit_en_i),
    .ext_sync_i(ext_sync_i), .brk_wr_i(brk_wr_i), .brk_val_i(brk_val_i),
    .tx_data_i(tx_data_i), .sync_found_o(sync_found_o), .char_bnd_o(char_bnd_o),
    .tx_en_o(tx_en_o), .brk_o(brk_o), .tx_line_o(tx_line_o),
    .tx_sync_len_o(tx_sync_len_o)
  );

  // ---------------- reference model ----------------
  function automatic bit m_is_sync(int m);
    return (m >= 1 && m <= 4);
  endfunction
  function automatic int m_rxlen(int m, bit s);
    if (m == 1) return s ? 6 : 8;
    if (m == 2) return s ? 12 : 16;
    if (m == 3) return 8;
    return 0;
  endfunction
  function automatic int m_txlen(int m, bit s);
    if (m == 1 || m == 4) return s ? 6 : 8;
    if (m == 2) return 16;
    if (m == 3) return 8;
    return 0;
  endfunction
  function automatic int m_chlen(int m, bit s);
    return ((m == 1 || m == 4) && s) ? 6 : 8;
  endfunction

  bit m_loop, m_short, m_brk, m_bnd;
  int m_state, m_cnt;
  bit m_hist[$];

  always @(posedge clk) begin
    bit act, hit, rel;
    int n, l, md;
    md = int'(mode_i);
    if (!rst_n) begin
      m_loop = 0; m_short = 0; m_brk = 0; m_bnd = 0;
      m_state = 0; m_cnt = 0; m_hist.delete();
    end else begin
      act = m_loop && m_is_sync(md);
      n = m_rxlen(md, m_short);
      l = m_chlen(md, m_short);
      m_bnd = 0; rel = 0;
      if (chan_rst_i) begin
        m_loop = 0; m_short = 0; m_state = 0; m_cnt = 0; m_brk = 0;
        m_hist.delete();
      end else begin
        if (!act) begin
          m_state = 0; m_cnt = 0; m_hist.delete();
        end else if (m_state == 0) begin
          if (rx_bit_en_i) begin
            m_hist.push_back(rx_bit_i);
            if (m_hist.size() > 16) void'(m_hist.pop_front());
            if (md == 4) hit = ext_sync_i;
            else begin
              hit = (n > 0) && (m_hist.size() >= n);
              for (int k = 0; k < n && hit; k++)
                if (m_hist[m_hist.size()-1-k] != sync_pat_i[k]) hit = 0;
            end
            if (hit) begin m_state = 1; m_cnt = 0; end
          end
        end else if (rx_bit_en_i) begin
          m_cnt++;
          if (m_cnt == l) begin
            m_cnt = 0; m_bnd = 1;
            if (m_state == 1) begin m_state = 2; rel = 1; end
          end
        end
        if (rel) m_brk = 0;
        else if (brk_wr_i) m_brk = brk_val_i;
        if (cfg_wr_i) begin m_loop = cfg_loop_i; m_short = cfg_short_i; end
      end
    end
  end

  task automatic cmp(string req, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d [%s] t=%0t", req, what, got, exp, phase, $time);
    end
  endtask

  always @(negedge clk) begin
    bit act_now, exp_line;
    if (!done) begin
      act_now  = m_loop && m_is_sync(int'(mode_i));
      exp_line = m_brk ? 1'b0 : ((act_now && m_state != 2) ? 1'b1 : tx_data_i);
      cmp("R2", "sync_found_o", int'(sync_found_o), int'(m_state != 0));
      cmp("R5", "char_bnd_o",   int'(char_bnd_o),   int'(m_bnd));
      cmp("R6", "tx_en_o",      int'(tx_en_o),      int'(m_state == 2));
      cmp("R8", "brk_o",        int'(brk_o),        int'(m_brk));
      cmp("R7", "tx_line_o",    int'(tx_line_o),    int'(exp_line));
      cmp("R11", "tx_sync_len_o", int'(tx_sync_len_o), m_txlen(int'(mode_i), m_short));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles [%s]", cyc, phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    #1;
    tx_data_i = 1'($urandom);
  endtask

  task automatic send_bit(bit b, bit ext = 0);
    rx_bit_i = b; ext_sync_i = ext; rx_bit_en_i = 1'b1;
    tick();
    rx_bit_en_i = 1'b0; ext_sync_i = 1'b0;
    if (gaps) repeat ($urandom % 3) tick();
  endtask

  task automatic send_random(int nb);
    for (int i = 0; i < nb; i++) send_bit(1'($urandom));
  endtask

  task automatic send_pattern(logic [15:0] p, int nb);
    for (int i = nb - 1; i >= 0; i--) send_bit(p[i]);
  endtask

  task automatic write_cfg(bit lp, bit sh);
    cfg_wr_i = 1; cfg_loop_i = lp; cfg_short_i = sh;
    tick();
    cfg_wr_i = 0;
  endtask

  task automatic write_brk(bit v);
    brk_wr_i = 1; brk_val_i = v;
    tick();
    brk_wr_i = 0;
  endtask

  task automatic run_loop(int md, bit sh, string ph, int pre, int post);
    phase = ph;
    mode_i = 3'(md);
    sync_pat_i = 16'($urandom);
    write_cfg(1, sh);
    send_random(pre);
    if (md == 4) send_bit(1'($urandom), 1'b1);
    else send_pattern(sync_pat_i, m_rxlen(md, sh));
    send_random(post);
    write_cfg(0, 0);
    repeat (3) tick();
  endtask

  initial begin
    rst_n = 0; chan_rst_i = 0; cfg_wr_i = 0; cfg_loop_i = 0; cfg_short_i = 0;
    mode_i = 3'd0; sync_pat_i = '0; rx_bit_i = 0; rx_bit_en_i = 0; ext_sync_i = 0;
    brk_wr_i = 0; brk_val_i = 0; tx_data_i = 0;
    phase = "R1 reset";
    repeat (4) tick();
    rst_n = 1;
    repeat (4) tick();

    phase = "R10 async ignores loop";
    mode_i = 3'd0;
    write_cfg(1, 1);
    send_random(30);
    write_brk(1);
    send_random(5);
    write_brk(0);
    mode_i = 3'd6;
    phase = "R10 unused mode code";
    send_random(20);
    write_cfg(0, 0);

    run_loop(1, 0, "R2 R3 monosync 8-bit", 12, 24);
    run_loop(1, 1, "R3 R5 monosync 6-bit", 12, 24);
    run_loop(2, 0, "R3 R11 bisync 16-bit", 20, 24);
    run_loop(2, 1, "R3 R11 bisync 12-bit rx, 16-bit tx", 20, 24);
    run_loop(3, 1, "R3 SDLC ignores short-sync", 12, 24);
    run_loop(4, 1, "R4 external sync short", 7, 20);
    run_loop(4, 0, "R4 external sync long", 7, 20);

    // history fill rule: all-zero pattern must wait for N bits
    phase = "R2 fill rule zero pattern";
    mode_i = 3'd1; sync_pat_i = 16'h0000;
    write_cfg(1, 0);
    for (int i = 0; i < 12; i++) send_bit(1'b0);
    send_random(20);
    write_cfg(0, 0);
    repeat (2) tick();

    // near miss followed by the correct pattern
    phase = "R2 near miss";
    mode_i = 3'd2; sync_pat_i = 16'hA5C3;
    write_cfg(1, 0);
    send_pattern(16'hA5C2, 16);
    send_bit(1'b1);
    send_pattern(16'hA5C3, 16);
    send_random(20);
    write_cfg(0, 0);
    repeat (2) tick();

    // break before sync, then write held through release
    phase = "R7 R8 break held through release";
    mode_i = 3'd1; sync_pat_i = 16'h007E;
    write_cfg(1, 0);
    send_random(6);
    write_brk(1);
    send_random(6);
    brk_wr_i = 1; brk_val_i = 1;
    send_pattern(sync_pat_i, 8);
    send_random(20);
    brk_wr_i = 0;
    write_brk(0);
    send_random(4);

    phase = "R9 loop cleared while active";
    write_cfg(0, 0);
    repeat (3) tick();
    send_random(10);

    phase = "R9 mode leaves sync while active";
    mode_i = 3'd2; sync_pat_i = 16'h1234;
    write_cfg(1, 1);
    send_pattern(16'h1234, 12);
    send_random(12);
    mode_i = 3'd0;
    repeat (3) tick();
    mode_i = 3'd2;
    send_random(6);
    send_pattern(16'h1234, 12);
    send_random(10);

    phase = "R12 channel reset beats config write";
    chan_rst_i = 1; cfg_wr_i = 1; cfg_loop_i = 1; cfg_short_i = 1;
    brk_wr_i = 1; brk_val_i = 1;
    tick();
    chan_rst_i = 0; cfg_wr_i = 0; brk_wr_i = 0;
    send_random(10);
    phase = "R1 R12 state after channel reset";
    repeat (3) tick();

    phase = "R2 R5 R6 random modes with gaps";
    gaps = 1;
    for (int it = 0; it < 24; it++)
      run_loop(1 + ($urandom % 4), 1'($urandom), "R2 R5 R6 random modes with gaps",
               $urandom % 20, 10 + ($urandom % 20));
    gaps = 0;

    repeat (4) tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule